// File: doc/BRIEF.md
# Fixed-Window PCI-to-VME Address Decoder

This block sits beside a group of programmable PCI target images. It watches each PCI address phase and decides whether the cycle falls inside one fixed 64 MB window that is reserved for short-address VMEbus traffic. A claimed cycle is translated for the VMEbus master with no offset added. The window holds four 16 MB regions. In each region the top 64 KB becomes an A16 access and everything below it becomes an A24 access. Along with the address, the block gives the privilege and data-width attributes that the VMEbus address modifier needs.

The window has the lowest priority of all target images. If any standard image reports a hit in the same address phase, the window stays silent. Software sets up a single configuration register: an enable bit, the 6-bit window base, the PCI space (memory or I/O), the privilege level and the data width. The decode result is registered, so the claim flag and all translated fields appear together one clock after the address phase is presented.

Top module: `vwin_decoder`

## Requirements
- R1: After reset the configuration register reads 0 and `win_claim` is 0.
- R2: A write with `cfg_we` high stores enable (bit 31), data width (bit 8, 1 = 32-bit), window base (bits 7:2), privilege (bit 1, 1 = supervisor) and space select (bit 0, 1 = I/O). All other bits read back as 0.
- R3: A cycle can be claimed only when address bits [31:26] equal the stored base.
- R4: With space select 0, only the memory command codes 4'h6, 4'h7, 4'hC, 4'hE and 4'hF can be claimed. With space select 1, only the I/O codes 4'h2 and 4'h3 can be claimed. No other code is ever claimed.
- R5: While the enable bit is 0, no cycle is claimed.
- R6: If any bit of `std_hit` is high during the address phase, the window does not claim that cycle.
- R7: On a claim, `vme_region` equals address bits [25:24].
- R8: On a claim, the access is A16 (`vme_is_a16`=1, `vme_addr` = {8'h00, addr[15:0]}) when address bits [23:16] are 8'hFF. Otherwise it is A24 with `vme_addr` = addr[23:0].
- R9: On a claim, `vme_super` and `vme_d32` equal the stored privilege and width bits. When there is no claim, `vme_addr`, `vme_is_a16`, `vme_region`, `vme_super` and `vme_d32` are all 0.
- R10: Results appear on the outputs one clock after the address phase. A configuration write on the same edge as an address phase does not affect the decode of that address phase.
- R11: When `req_valid` is 0, nothing is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration register contents |
| req_valid | input | 1 | PCI address phase present |
| req_addr | input | 32 | PCI address |
| req_cmd | input | 4 | PCI command code |
| std_hit | input | 8 | Hit flags from the standard target images |
| win_claim | output | 1 | Window claims the cycle |
| vme_addr | output | 24 | Translated VMEbus address |
| vme_is_a16 | output | 1 | 1 = A16 space, 0 = A24 space |
| vme_region | output | 2 | Selected 16 MB region |
| vme_super | output | 1 | Supervisor access attribute |
| vme_d32 | output | 1 | 32-bit data width attribute |

## Verification
Two functions can act on the same clock edge: a configuration write and an address phase being decoded. The bench provokes this in two ways. It moves the base away from an address that currently hits, and it sets the enable bit in the same cycle as a matching request. In both cases it expects the decode to follow the configuration that held before the edge. The read-back value and the decode of the next request must follow the new configuration. The bench also lets the priority suppression and the A16/A24 region boundary fall on the same address phase.

// File: rtl/vwin_pkg.sv
package vwin_pkg;

  // configuration bit positions (base field position is fixed by its decoder)
  localparam int CFG_W      = 32;
  localparam int BIT_IO     = 0;
  localparam int BIT_SUPER  = 1;
  localparam int BASE_LO    = 2;
  localparam int BASE_HI    = 7;
  localparam int BIT_D32    = 8;
  localparam int BIT_EN     = 31;

  typedef struct packed {
    logic       en;
    logic       d32;
    logic [5:0] base;
    logic       super_acc;
    logic       io_space;
  } win_cfg_t;

  typedef struct packed {
    logic        a16;
    logic [1:0]  region;
    logic [23:0] addr;
  } win_xlat_t;

  function automatic win_cfg_t cfg_from_word(input logic [CFG_W-1:0] w);
    win_cfg_t c;
    c.en        = w[BIT_EN];
    c.d32       = w[BIT_D32];
    c.base      = w[BASE_HI:BASE_LO];
    c.super_acc = w[BIT_SUPER];
    c.io_space  = w[BIT_IO];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_to_word(input win_cfg_t c);
    logic [CFG_W-1:0] w;
    w = '0;
    w[BIT_EN]           = c.en;
    w[BIT_D32]          = c.d32;
    w[BASE_HI:BASE_LO]  = c.base;
    w[BIT_SUPER]        = c.super_acc;
    w[BIT_IO]           = c.io_space;
    return w;
  endfunction

  function automatic logic cmd_is_mem(input logic [3:0] cmd);
    case (cmd)
      4'h6, 4'h7, 4'hC, 4'hE, 4'hF: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  function automatic logic cmd_is_io(input logic [3:0] cmd);
    return (cmd[3:1] == 3'b001);
  endfunction

  // true when the region-relative bits point into the uppermost 64 KB
  function automatic logic in_top_64k(input logic [7:0] mid);
    return &mid;
  endfunction

endpackage

// File: rtl/vwin_cfg_reg.sv
module vwin_cfg_reg
  import vwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output win_cfg_t         cfg,
  output logic [CFG_W-1:0] rdata
);
  win_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= cfg_from_word(wdata);
  end

  assign cfg   = cfg_q;
  assign rdata = cfg_to_word(cfg_q);
endmodule

// File: rtl/vwin_match.sv
module vwin_match
  import vwin_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BASE_W  = 6,
  parameter int NUM_STD = 8
) (
  input  win_cfg_t           cfg,
  input  logic               valid,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [3:0]         cmd,
  input  logic [NUM_STD-1:0] std_hit,
  output logic               base_hit,
  output logic               cmd_ok,
  output logic               higher_hit,
  output logic               claim
);
  localparam int WIN_LSB = ADDR_W - BASE_W;

  // OR of the higher-priority hits, built as a chain
  logic [NUM_STD:0] any_chain;
  assign any_chain[0] = 1'b0;
  for (genvar i = 0; i < NUM_STD; i++) begin : g_pri
    assign any_chain[i+1] = any_chain[i] | std_hit[i];
  end
  assign higher_hit = any_chain[NUM_STD];

  assign base_hit = (addr[ADDR_W-1:WIN_LSB] == cfg.base);
  assign cmd_ok   = cfg.io_space ? cmd_is_io(cmd) : cmd_is_mem(cmd);
  assign claim    = valid & cfg.en & base_hit & cmd_ok & ~higher_hit;
endmodule

// File: rtl/vwin_xlate.sv
module vwin_xlate
  import vwin_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int REGION_W = 2,
  parameter int A24_W    = 24,
  parameter int A16_W    = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output win_xlat_t         xl
);
  localparam int MID_W = A24_W - A16_W;

  logic [MID_W-1:0] mid;
  assign mid = addr[A24_W-1:A16_W];

  always_comb begin
    xl.region = addr[A24_W+REGION_W-1:A24_W];
    xl.a16    = in_top_64k(mid);
    if (xl.a16) xl.addr = {{MID_W{1'b0}}, addr[A16_W-1:0]};
    else        xl.addr = addr[A24_W-1:0];
  end
endmodule

// File: rtl/vwin_decoder.sv
module vwin_decoder
  import vwin_pkg::*;
#(
  parameter int NUM_STD = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic               req_valid,
  input  logic [31:0]        req_addr,
  input  logic [3:0]         req_cmd,
  input  logic [NUM_STD-1:0] std_hit,
  output logic               win_claim,
  output logic [23:0]        vme_addr,
  output logic               vme_is_a16,
  output logic [1:0]         vme_region,
  output logic               vme_super,
  output logic               vme_d32
);
  win_cfg_t  cfg;
  win_xlat_t xl;
  logic      base_hit, cmd_ok, higher_hit, claim_d;

  vwin_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .cfg(cfg), .rdata(cfg_rdata)
  );

  vwin_match #(.ADDR_W(32), .BASE_W(6), .NUM_STD(NUM_STD)) u_match (
    .cfg(cfg), .valid(req_valid), .addr(req_addr), .cmd(req_cmd),
    .std_hit(std_hit), .base_hit(base_hit), .cmd_ok(cmd_ok),
    .higher_hit(higher_hit), .claim(claim_d)
  );

  vwin_xlate #(.ADDR_W(32), .REGION_W(2), .A24_W(24), .A16_W(16)) u_xl (
    .addr(req_addr), .xl(xl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_claim  <= 1'b0;
      vme_addr   <= '0;
      vme_is_a16 <= 1'b0;
      vme_region <= '0;
      vme_super  <= 1'b0;
      vme_d32    <= 1'b0;
    end else begin
      win_claim  <= claim_d;
      vme_addr   <= claim_d ? xl.addr : '0;
      vme_is_a16 <= claim_d & xl.a16;
      vme_region <= claim_d ? xl.region : '0;
      vme_super  <= claim_d & cfg.super_acc;
      vme_d32    <= claim_d & cfg.d32;
    end
  end
endmodule

// File: rtl/vwin_checker.sv
module vwin_checker #(
  parameter int NUM_STD = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [31:0]        cfg_rdata,
  input logic               req_valid,
  input logic [31:0]        req_addr,
  input logic [3:0]         req_cmd,
  input logic [NUM_STD-1:0] std_hit,
  input logic               win_claim,
  input logic [23:0]        vme_addr,
  input logic               vme_is_a16,
  input logic [1:0]         vme_region,
  input logic               vme_super,
  input logic               vme_d32
);
  // R2: reserved configuration bits stay zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & 32'h7FFF_FE00) == 32'h0);

  // R3: claim implies base match against the configuration that held then
  a_r3_base_match: assert property (@(posedge clk) disable iff (!rst_n)
    win_claim |-> ($past(req_addr[31:26]) == $past(cfg_rdata[7:2])));

  // R5: no claim while disabled
  a_r5_enable_needed: assert property (@(posedge clk) disable iff (!rst_n)
    win_claim |-> $past(cfg_rdata[31]));

  // R6: standard images take priority
  a_r6_priority: assert property (@(posedge clk) disable iff (!rst_n)
    win_claim |-> $past(std_hit) == '0);

  // R7: region follows the address
  a_r7_region: assert property (@(posedge clk) disable iff (!rst_n)
    win_claim |-> vme_region == $past(req_addr[25:24]));

  // R8: A16 results carry no upper address bits
  a_r8_a16_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (win_claim && vme_is_a16) |-> vme_addr[23:16] == 8'h00);

  // R9: outputs quiet without a claim
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !win_claim |-> (vme_addr == '0 && !vme_is_a16 && vme_region == '0
                    && !vme_super && !vme_d32));

  // R11: nothing claimed without an address phase
  a_r11_valid_needed: assert property (@(posedge clk) disable iff (!rst_n)
    win_claim |-> $past(req_valid));
endmodule

bind vwin_decoder vwin_checker #(.NUM_STD(NUM_STD)) u_vwin_checker (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
  .req_addr(req_addr), .req_cmd(req_cmd), .std_hit(std_hit),
  .win_claim(win_claim), .vme_addr(vme_addr), .vme_is_a16(vme_is_a16),
  .vme_region(vme_region), .vme_super(vme_super), .vme_d32(vme_d32)
);

// File: tb/test_vwin_decoder.sv
`timescale 1ns/1ps
module test_vwin_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_cmd = '0;
  logic [7:0]  std_hit = '0;
  logic        win_claim, vme_is_a16, vme_super, vme_d32;
  logic [23:0] vme_addr;
  logic [1:0]  vme_region;

  int checks = 0;
  int failures = 0;
  logic [31:0] shadow = '0;
  bit done = 0;

  always #4 clk = ~clk;

  vwin_decoder i_vwin_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_cmd(req_cmd), .std_hit(std_hit), .win_claim(win_claim),
    .vme_addr(vme_addr), .vme_is_a16(vme_is_a16), .vme_region(vme_region),
    .vme_super(vme_super), .vme_d32(vme_d32)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit model_claim(input logic [31:0] c, input bit v,
                                     input logic [31:0] a, input logic [3:0] k,
                                     input logic [7:0] h);
    bit typ;
    if (c[0]) typ = 16'h000C >> k;
    else      typ = 16'hD0C0 >> k;
    return v && c[31] && (a[31:26] == c[7:2]) && typ && (h == 0);
  endfunction

  // expected output bundle {claim, a16, region, super, d32, addr}
  function automatic logic [29:0] model_out(input logic [31:0] c, input bit v,
                                            input logic [31:0] a, input logic [3:0] k,
                                            input logic [7:0] h);
    bit cl, s16;
    logic [23:0] va;
    cl = model_claim(c, v, a, k, h);
    if (!cl) return '0;
    s16 = (a[23:16] == 8'hFF);
    va  = s16 ? {8'h00, a[15:0]} : a[23:0];
    return {1'b1, s16, a[25:24], c[1], c[8], va};
  endfunction

  task automatic write_cfg(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    shadow = d & 32'h8000_01FF;
  endtask

  task automatic run_req(input string tag, input bit v, input logic [31:0] a,
                         input logic [3:0] k, input logic [7:0] h);
    logic [29:0] exp;
    @(negedge clk);
    req_valid = v; req_addr = a; req_cmd = k; std_hit = h;
    exp = model_out(shadow, v, a, k, h);
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, {win_claim, vme_is_a16, vme_region, vme_super, vme_d32, vme_addr}, exp);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cfg reset", cfg_rdata, 32'h0);
    chk("R1 claim reset", win_claim, 1'b0);

    write_cfg(32'hFFFF_FFFF);
    chk("R2 reserved masked", cfg_rdata, 32'h8000_01FF);

    // memory space, base 0x05, supervisor, 32-bit
    write_cfg(32'h8000_0100 | (32'h05 << 2) | 32'h2);
    chk("R2 readback", cfg_rdata, 32'h8000_0116);
    run_req("R3 R8 R9 A24 hit", 1, 32'h1612_3456, 4'h6, 8'h00);
    run_req("R8 A16 top of region", 1, 32'h17FF_ABCD, 4'h7, 8'h00);
    run_req("R8 just below A16", 1, 32'h15FE_FFFF, 4'hC, 8'h00);
    run_req("R3 outside window", 1, 32'h1A00_0000, 4'h6, 8'h00);
    run_req("R4 io code in mem space", 1, 32'h1400_0000, 4'h2, 8'h00);
    run_req("R4 config code rejected", 1, 32'h1400_0000, 4'hA, 8'h00);
    run_req("R6 std hit blocks", 1, 32'h14FF_0010, 4'hE, 8'h80);
    run_req("R6 R8 std hit low bit", 1, 32'h14FF_0010, 4'hF, 8'h01);
    run_req("R11 no valid", 0, 32'h1400_0000, 4'h6, 8'h00);
    run_req("R7 region 3", 1, 32'h1700_0004, 4'h6, 8'h00);

    // I/O space, user, 16-bit
    write_cfg(32'h8000_0000 | (32'h3F << 2) | 32'h1);
    run_req("R4 io read", 1, 32'hFEFF_0022, 4'h2, 8'h00);
    run_req("R4 io write A24", 1, 32'hFC01_0022, 4'h3, 8'h00);
    run_req("R4 mem code in io space", 1, 32'hFC01_0022, 4'h6, 8'h00);

    // disabled
    write_cfg(32'h0000_0000 | (32'h3F << 2) | 32'h1);
    run_req("R5 disabled", 1, 32'hFEFF_0022, 4'h2, 8'h00);

    // R10: enable on the same edge as a matching request -> old config used
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 32'h8000_0000 | (32'h3F << 2) | 32'h1;
    req_valid = 1'b1; req_addr = 32'hFEFF_0022; req_cmd = 4'h2; std_hit = 0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    shadow = 32'h8000_00FD;
    chk("R10 same-edge write uses old cfg", win_claim, 1'b0);
    chk("R10 new cfg visible", cfg_rdata, 32'h8000_00FD);
    run_req("R10 next request uses new cfg", 1, 32'hFEFF_0022, 4'h2, 8'h00);

    // R10: move base away on the edge of a hitting request -> still claimed
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 32'h8000_0000 | (32'h01 << 2) | 32'h1;
    req_valid = 1'b1; req_addr = 32'hFD00_1000; req_cmd = 4'h3; std_hit = 0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R10 old base claims", {win_claim, vme_addr}, {1'b1, 24'h00_1000});
    shadow = 32'h8000_0005;
    run_req("R10 R3 moved base misses", 1, 32'hFD00_1000, 4'h3, 8'h00);

    // random stimulus around the window
    for (int i = 0; i < 400; i++) begin
      logic [31:0] c, a;
      logic [3:0]  k;
      logic [7:0]  h;
      if (i % 50 == 0) begin
        c = $urandom();
        c[31] = ($urandom() % 4) != 0;
        write_cfg(c);
      end
      a = $urandom();
      if ($urandom() % 3 != 0) a[31:26] = shadow[7:2];
      if ($urandom() % 4 == 0) a[23:16] = 8'hFF;
      k = $urandom();
      h = ($urandom() % 4 == 0) ? 8'($urandom()) : 8'h00;
      run_req("R3 R4 R6 R7 R8 R9 random", ($urandom() % 8) != 0, a, k, h);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule